// File: doc/BRIEF.md
# ARINC 429 Receive Bit and Word-Gap Validator

This block sits behind an external line comparator on an ARINC 429 style receive path. Each cycle of a 1 MHz reference clock, with an error under 0.1%, the comparator reports the line level as One, Zero, Null, or none of these. The block keeps a ten-sample history for each of the three levels. It accepts a data bit only when the history shows a clean pulse that has returned to Null. It then emits the bit value with a one-cycle strobe.

Consecutive bits must be spaced within a fixed window of samples. A bit that comes too late, or too early, aborts the word. Between words the block watches for a sustained Null gap, tested at a coarse interval, and only arms itself for the next word once that gap has been seen enough times in a row.

A speed input selects the low-speed timing. In that mode the history advances only once every eighth reference clock, so the same sample-count rules cover the slower bit rate. Word assembly, parity and host readout belong to the blocks downstream.

Top module: `a429_bit_validator`

## Requirements
- R1: A sample in which more than one of `lvl_one`, `lvl_zero`, `lvl_null` is high is recorded as no level at all. No two level histories ever hold a 1 in the same position, and a pulse made only of such conflicting samples produces no strobe.
- R2: A bit is accepted when the older half of the One history (or the Zero history) holds at least three consecutive 1s while the newer half of the Null history holds at least three consecutive 1s. Each such pulse gives exactly one `bit_vld` strobe. `bit_val` is 1 for a One pulse and 0 for a Zero pulse.
- R3: Inside a word, a bit that follows the previous accepted bit after any spacing from 8 to 12 samples inclusive is accepted without error.
- R4: A spacing above 12 samples (or below 8) gives a one-cycle `spc_err` pulse with no strobe in that cycle. It also aborts the word, and no further bit is accepted until a new word gap has been qualified.
- R5: Outside a word, every 10th sample tests the Null history. A test passes when each half holds at least three consecutive 1s. Three passing tests in a row set `rx_ready`, and a failing test clears the run.
- R6: After reset, all outputs are low and `rx_ready` is low. Bit pulses arriving before a word gap has been qualified are ignored.
- R7: The first bit accepted while `rx_ready` is high is strobed with `word_start` high. `rx_ready` drops in the same cycle.
- R8: After 32 accepted bits the word ends without error, and the block returns to gap qualification before it accepts another word.
- R9: With `slow_mode` high, the histories, the spacing count and the gap test advance once every 8 reference clocks, so bits held for 8-clock samples are accepted under the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1 selects low-speed timing (one sample per 8 clocks) |
| lvl_one | input | 1 | Comparator reports the line in the One band |
| lvl_zero | input | 1 | Comparator reports the line in the Zero band |
| lvl_null | input | 1 | Comparator reports the line in the Null band |
| bit_vld | output | 1 | One-cycle strobe for an accepted bit |
| bit_val | output | 1 | Value of the accepted bit, valid with `bit_vld` |
| word_start | output | 1 | Marks the strobe of the first bit of a word |
| spc_err | output | 1 | One-cycle pulse when bit spacing breaks the window |
| rx_ready | output | 1 | High while a qualified gap has armed reception |

## Verification
A bit edge and the late-spacing timeout can land in the same cycle. With a steady stream whose period is 13 samples, the spacing count reaches its overflow value in exactly the cycle where the second pulse is recognised. The stream is built that way on purpose. The scoreboard then expects only the first bit, flagged as a word start, and the error monitor expects exactly one `spc_err` pulse. No strobe may follow until the later Null gap re-arms the block and a fresh word is accepted.

// File: rtl/a429_bv_pkg.sv
package a429_bv_pkg;

  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_ARMED = 2'd1,
    ST_WORD  = 2'd2
  } seq_state_t;

  localparam int unsigned NUM_BANDS = 3;
  localparam int unsigned BAND_ONE  = 0;
  localparam int unsigned BAND_ZERO = 1;
  localparam int unsigned BAND_NULL = 2;

endpackage

// File: rtl/a429_bv_sampler.sv
module a429_bv_sampler
  import a429_bv_pkg::*;
#(
  parameter int unsigned DEPTH    = 10,
  parameter int unsigned SLOW_DIV = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 slow_mode,
  input  logic                                 lvl_one,
  input  logic                                 lvl_zero,
  input  logic                                 lvl_null,
  output logic                                 samp_en,
  output logic [NUM_BANDS-1:0][DEPTH-1:0]      hist
);

  localparam int unsigned PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [PW-1:0]        pre_q, pre_d;
  logic [NUM_BANDS-1:0] raw, clean;

  // prescaler: free running, only consulted in low-speed mode
  always_comb begin
    if (pre_q == PW'(SLOW_DIV - 1)) pre_d = '0;
    else                            pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign samp_en = slow_mode ? (pre_q == PW'(SLOW_DIV - 1)) : 1'b1;

  // a conflicting report counts as a between-band sample
  always_comb begin
    raw = '0;
    raw[BAND_ONE]  = lvl_one;
    raw[BAND_ZERO] = lvl_zero;
    raw[BAND_NULL] = lvl_null;
    if ((raw & (raw - NUM_BANDS'(1))) == '0) clean = raw;
    else                                     clean = '0;
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANDS; b++) begin : g_band
      logic [DEPTH-1:0] sr_q, sr_d;

      always_comb begin
        if (samp_en) sr_d = {sr_q[DEPTH-2:0], clean[b]};
        else         sr_d = sr_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
      end

      assign hist[b] = sr_q;
    end
  endgenerate

endmodule

// File: rtl/a429_bv_detect.sv
module a429_bv_detect
  import a429_bv_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned RUN   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BANDS-1:0][DEPTH-1:0] hist,
  output logic                            det,
  output logic                            det_val,
  output logic                            gap_null
);

  localparam int unsigned HALF = DEPTH / 2;

  function automatic logic has_run(input logic [HALF-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i <= int'(HALF - RUN); i++) begin
      if (&v[i +: RUN]) hit = 1'b1;
    end
    return hit;
  endfunction

  logic one_old, zero_old, null_old, null_new;
  logic cond, cond_q;

  // bit 0 is the newest sample, so the upper half is the older one
  assign one_old  = has_run(hist[BAND_ONE][DEPTH-1:DEPTH-HALF]);
  assign zero_old = has_run(hist[BAND_ZERO][DEPTH-1:DEPTH-HALF]);
  assign null_old = has_run(hist[BAND_NULL][DEPTH-1:DEPTH-HALF]);
  assign null_new = has_run(hist[BAND_NULL][HALF-1:0]);

  assign cond     = (one_old | zero_old) & null_new;
  assign gap_null = null_old & null_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign det     = cond & ~cond_q;
  assign det_val = one_old;

endmodule

// File: rtl/a429_bv_seq.sv
module a429_bv_seq
  import a429_bv_pkg::*;
#(
  parameter int unsigned SPC_MIN     = 8,
  parameter int unsigned SPC_MAX     = 12,
  parameter int unsigned GAP_SAMPLES = 10,
  parameter int unsigned GAP_NEED    = 3,
  parameter int unsigned WORD_BITS   = 32,
  localparam int unsigned SW = $clog2(SPC_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  input  logic          det,
  input  logic          det_val,
  input  logic          gap_null,
  output logic          bit_vld,
  output logic          bit_val,
  output logic          word_start,
  output logic          spc_err,
  output logic          rx_ready,
  output logic [SW-1:0] spc_cnt
);

  localparam int unsigned GW = $clog2(GAP_SAMPLES);
  localparam int unsigned CW = $clog2(GAP_NEED + 1);
  localparam int unsigned BW = $clog2(WORD_BITS);

  seq_state_t    st_q, st_d;
  logic [SW-1:0] spc_q, spc_d;
  logic [GW-1:0] gtmr_q, gtmr_d;
  logic [CW-1:0] gcnt_q, gcnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          vld_q, vld_d, val_q, val_d, start_q, start_d, err_q, err_d;
  logic          in_win, late;
  logic [SW-1:0] spc_rst;

  assign in_win  = (spc_q >= SW'(SPC_MIN)) && (spc_q <= SW'(SPC_MAX));
  assign late    = spc_q > SW'(SPC_MAX);
  // the sample landing in the accepting cycle already belongs to the next interval
  assign spc_rst = samp_en ? SW'(1) : '0;

  always_comb begin
    st_d    = st_q;
    spc_d   = spc_q;
    gtmr_d  = gtmr_q;
    gcnt_d  = gcnt_q;
    bcnt_d  = bcnt_q;
    vld_d   = 1'b0;
    val_d   = val_q;
    start_d = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_GAP: begin
        if (samp_en) begin
          if (gtmr_q == GW'(GAP_SAMPLES - 1)) begin
            gtmr_d = '0;
            if (gap_null) begin
              if (gcnt_q == CW'(GAP_NEED - 1)) begin
                gcnt_d = '0;
                st_d   = ST_ARMED;
              end else begin
                gcnt_d = gcnt_q + CW'(1);
              end
            end else begin
              gcnt_d = '0;
            end
          end else begin
            gtmr_d = gtmr_q + GW'(1);
          end
        end
      end
      ST_ARMED: begin
        if (det) begin
          vld_d   = 1'b1;
          start_d = 1'b1;
          val_d   = det_val;
          bcnt_d  = BW'(1);
          spc_d   = spc_rst;
          st_d    = ST_WORD;
        end
      end
      ST_WORD: begin
        if (det && in_win) begin
          vld_d = 1'b1;
          val_d = det_val;
          spc_d = spc_rst;
          if (bcnt_q == BW'(WORD_BITS - 1)) begin
            st_d   = ST_GAP;
            gtmr_d = '0;
            gcnt_d = '0;
          end else begin
            bcnt_d = bcnt_q + BW'(1);
          end
        end else if (det || late) begin
          err_d  = 1'b1;
          st_d   = ST_GAP;
          gtmr_d = '0;
          gcnt_d = '0;
        end else if (samp_en) begin
          spc_d = spc_q + SW'(1);
        end
      end
      default: st_d = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_GAP;
      spc_q   <= '0;
      gtmr_q  <= '0;
      gcnt_q  <= '0;
      bcnt_q  <= '0;
      vld_q   <= 1'b0;
      val_q   <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      spc_q   <= spc_d;
      gtmr_q  <= gtmr_d;
      gcnt_q  <= gcnt_d;
      bcnt_q  <= bcnt_d;
      vld_q   <= vld_d;
      val_q   <= val_d;
      start_q <= start_d;
      err_q   <= err_d;
    end
  end

  assign bit_vld    = vld_q;
  assign bit_val    = val_q;
  assign word_start = start_q;
  assign spc_err    = err_q;
  assign rx_ready   = (st_q == ST_ARMED);
  assign spc_cnt    = spc_q;

endmodule

// File: rtl/a429_bit_validator.sv
module a429_bit_validator
  import a429_bv_pkg::*;
#(
  parameter int unsigned DEPTH       = 10,
  parameter int unsigned RUN         = 3,
  parameter int unsigned SLOW_DIV    = 8,
  parameter int unsigned SPC_MIN     = 8,
  parameter int unsigned SPC_MAX     = 12,
  parameter int unsigned GAP_SAMPLES = 10,
  parameter int unsigned GAP_NEED    = 3,
  parameter int unsigned WORD_BITS   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_mode,
  input  logic lvl_one,
  input  logic lvl_zero,
  input  logic lvl_null,
  output logic bit_vld,
  output logic bit_val,
  output logic word_start,
  output logic spc_err,
  output logic rx_ready
);

  localparam int unsigned SPC_W = $clog2(SPC_MAX + 2);

  logic                            samp_en;
  logic [NUM_BANDS-1:0][DEPTH-1:0] hist;
  logic                            det, det_val, gap_null;
  logic [SPC_W-1:0]                spc_cnt;

  a429_bv_sampler #(
    .DEPTH    (DEPTH),
    .SLOW_DIV (SLOW_DIV)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_mode (slow_mode),
    .lvl_one   (lvl_one),
    .lvl_zero  (lvl_zero),
    .lvl_null  (lvl_null),
    .samp_en   (samp_en),
    .hist      (hist)
  );

  a429_bv_detect #(
    .DEPTH (DEPTH),
    .RUN   (RUN)
  ) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .hist     (hist),
    .det      (det),
    .det_val  (det_val),
    .gap_null (gap_null)
  );

  a429_bv_seq #(
    .SPC_MIN     (SPC_MIN),
    .SPC_MAX     (SPC_MAX),
    .GAP_SAMPLES (GAP_SAMPLES),
    .GAP_NEED    (GAP_NEED),
    .WORD_BITS   (WORD_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .det        (det),
    .det_val    (det_val),
    .gap_null   (gap_null),
    .bit_vld    (bit_vld),
    .bit_val    (bit_val),
    .word_start (word_start),
    .spc_err    (spc_err),
    .rx_ready   (rx_ready),
    .spc_cnt    (spc_cnt)
  );

endmodule

// File: rtl/a429_bit_validator_chk.sv
module a429_bit_validator_chk
  import a429_bv_pkg::*;
#(
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned SW      = 4,
  parameter int unsigned SPC_MIN = 8,
  parameter int unsigned SPC_MAX = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            slow_mode,
  input logic                            samp_en,
  input logic [NUM_BANDS-1:0][DEPTH-1:0] hist,
  input logic                            bit_vld,
  input logic                            word_start,
  input logic                            spc_err,
  input logic                            rx_ready,
  input logic [SW-1:0]                   spc_cnt
);

  // R1: no history position may record two bands
  p_band_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist[BAND_ONE] & hist[BAND_ZERO]) | (hist[BAND_ONE] & hist[BAND_NULL]) |
     (hist[BAND_ZERO] & hist[BAND_NULL])) == '0);

  // R3: a strobe inside a word follows a spacing inside the window
  p_spacing_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !word_start) |->
      ($past(spc_cnt) >= SW'(SPC_MIN) && $past(spc_cnt) <= SW'(SPC_MAX)));

  // R4: an error pulse disarms and carries no strobe
  p_err_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spc_err |-> (!rx_ready && !bit_vld));

  // R7: a word start comes from the armed state
  p_start_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (bit_vld && $past(rx_ready) && !rx_ready));

  // R9: in low-speed mode sample enables are never back to back
  p_slow_pace_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && samp_en) |=> (!samp_en || !slow_mode));

endmodule

bind a429_bit_validator a429_bit_validator_chk #(
  .DEPTH   (DEPTH),
  .SW      (SPC_W),
  .SPC_MIN (SPC_MIN),
  .SPC_MAX (SPC_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_mode  (slow_mode),
  .samp_en    (samp_en),
  .hist       (hist),
  .bit_vld    (bit_vld),
  .word_start (word_start),
  .spc_err    (spc_err),
  .rx_ready   (rx_ready),
  .spc_cnt    (spc_cnt)
);

// File: tb/a429_bit_validator_bench.sv
`timescale 1ns/1ps
module a429_bit_validator_bench;

  typedef struct {
    logic  val;
    logic  start;
    string req;
  } exp_t;

  logic clk, rst_n, slow_mode, lvl_one, lvl_zero, lvl_null;
  logic bit_vld, bit_val, word_start, spc_err, rx_ready;

  int   n_checks = 0;
  int   n_errors = 0;
  int   err_seen = 0;
  int   err_exp  = 0;
  bit   done     = 0;
  exp_t sb[$];

  a429_bit_validator u_a429_bit_validator (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_mode  (slow_mode),
    .lvl_one    (lvl_one),
    .lvl_zero   (lvl_zero),
    .lvl_null   (lvl_null),
    .bit_vld    (bit_vld),
    .bit_val    (bit_val),
    .word_start (word_start),
    .spc_err    (spc_err),
    .rx_ready   (rx_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // monitor: pops the scoreboard on each strobe, counts error pulses
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (spc_err) err_seen++;
      if (bit_vld) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(bit_val === e.val, e.req, "bit value", int'(bit_val), int'(e.val));
          check(word_start === e.start, "R7", "word_start flag",
                int'(word_start), int'(e.start));
        end
      end
    end
  end

  task automatic put_sample(input logic o, input logic z, input logic n);
    lvl_one  = o;
    lvl_zero = z;
    lvl_null = n;
    repeat (slow_mode ? 8 : 1) @(negedge clk);
  endtask

  task automatic nulls(input int cnt);
    repeat (cnt) put_sample(1'b0, 1'b0, 1'b1);
  endtask

  task automatic send_bit(input logic v, input int pw, input int nw,
                          input bit expect_it, input bit start_it, input string req);
    if (expect_it) begin
      exp_t e;
      e.val = v; e.start = start_it; e.req = req;
      sb.push_back(e);
    end
    repeat (pw) put_sample(v, ~v, 1'b0);
    nulls(nw);
  endtask

  task automatic send_word(input logic [31:0] w, input int pw, input int nw,
                           input int nbits, input bit expect_it, input string req);
    for (int i = 0; i < nbits; i++)
      send_bit(w[i], pw, nw, expect_it, expect_it && (i == 0), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_mode = 1'b0;
    lvl_one = 1'b0; lvl_zero = 1'b0; lvl_null = 1'b0;
    repeat (3) @(negedge clk);
    // R6: reset state
    check(bit_vld == 1'b0 && word_start == 1'b0, "R6", "strobes in reset", int'(bit_vld), 0);
    check(spc_err == 1'b0, "R6", "error in reset", int'(spc_err), 0);
    check(rx_ready == 1'b0, "R6", "ready in reset", int'(rx_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: bits before any qualified gap are ignored
    send_word(32'h0000_00B5, 5, 5, 6, 1'b0, "R6");
    check(rx_ready == 1'b0, "R6", "ready before gap", int'(rx_ready), 0);
    nulls(60);
    check(rx_ready == 1'b1, "R5", "ready after null gap", int'(rx_ready), 1);

    // R1: conflicting one+zero pulses record nothing
    repeat (4) begin
      repeat (5) put_sample(1'b1, 1'b1, 1'b0);
      nulls(5);
    end
    check(rx_ready == 1'b1, "R1", "still armed after conflicting pulses", int'(rx_ready), 1);
    check(sb.size() == 0, "R1", "scoreboard empty", sb.size(), 0);

    // R2/R8: nominal word, 10-sample spacing
    send_word(32'hA5C3_0F96, 5, 5, 32, 1'b1, "R2");
    nulls(3);
    check(rx_ready == 1'b0, "R8", "re-gap needed after word", int'(rx_ready), 0);
    check(err_seen == 0, "R8", "no error on complete word", err_seen, 0);
    nulls(60);

    // R3: tightest spacing
    send_word(32'h5A3C_F069, 3, 5, 32, 1'b1, "R3");
    nulls(60);
    // R3: widest spacing
    send_word(32'h1234_ABCD, 5, 7, 32, 1'b1, "R3");
    nulls(60);
    check(err_seen == 0, "R3", "no error at window edges", err_seen, 0);

    // R4: 13-sample spacing; only the first bit is taken
    send_bit(1'b1, 6, 7, 1'b1, 1'b1, "R4");
    err_exp++;
    send_word(32'h0000_000A, 6, 7, 5, 1'b0, "R4");
    check(err_seen == err_exp, "R4", "late spacing error count", err_seen, err_exp);
    check(rx_ready == 1'b0, "R4", "aborted word not re-armed", int'(rx_ready), 0);
    nulls(60);
    check(rx_ready == 1'b1, "R5", "re-armed after abort", int'(rx_ready), 1);

    // R5: a short gap does not arm the next word
    send_word(32'hDEAD_BEEF, 5, 5, 32, 1'b1, "R2");
    nulls(15);
    send_word(32'hFFFF_0000, 5, 5, 32, 1'b0, "R5");
    check(rx_ready == 1'b0, "R5", "short gap stays disarmed", int'(rx_ready), 0);
    nulls(60);
    send_word(32'h0F0F_3C3C, 5, 5, 32, 1'b1, "R5");
    nulls(10);

    // R9: low-speed timing
    slow_mode = 1'b1;
    nulls(60);
    check(rx_ready == 1'b1, "R9", "armed in low speed", int'(rx_ready), 1);
    send_word(32'h9669_C33C, 5, 5, 32, 1'b1, "R9");
    nulls(20);

    check(sb.size() == 0, "R2", "all expected bits seen", sb.size(), 0);
    check(err_seen == err_exp, "R4", "total error pulses", err_seen, err_exp);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule